// File: doc/BRIEF.md
# Actor Clock Enabler with Per-Queue Backpressure Control

This block derives a gated clock for one dataflow actor from a free-running domain clock. The actor may write to several output ports, and a port may feed more than one queue. Every such queue reports two status flags: full, and almost-full (set when a single free slot remains). The block watches these flags and stops the actor's clock while any downstream queue cannot take more data. The gated clock also drives the write and read clocks of the queues attached to the actor.

Each output queue has its own five-state backpressure controller. A merge stage ANDs the controller enables per port, following a compile-time queue-to-port map, and then ANDs the port results. The merged enable passes through one flip-flop. A clock-gating cell then passes the domain clock only while that registered enable, captured during the low phase, is high. The map can express a single fanned-out port, two separate ports, or a fanned-out port next to another port.

Top module: `actor_clk_enabler`

## Requirements
- R1: While reset is held and on its release, the registered enable `actor_en_o` is 1, every controller is in its start state, and `actor_clk_o` follows `dom_clk`.
- R2: A controller in its start state keeps its enable high whatever its flags show. It moves to its free state at the first rising edge where full and almost-full are both 0.
- R3: A controller in its free state moves to a hold-off state with its enable at 0 on the first edge where either full or almost-full is 1.
- R4: In hold-off the enable stays 0. Full=1 moves it to the stopped state. Full=0 with almost-full=0 moves it to the resume state. Otherwise it stays in hold-off.
- R5: In the stopped state the enable stays 0 while full is 1. The first edge with full=0 moves it to the resume state, where the enable is 1.
- R6: From resume, full=1 leads to stopped, almost-full=1 (with full=0) leads to hold-off, and no flag leads to the free state. The enable is 1 only in the start, free and resume states.
- R7: The merged enable is 1 exactly when every controller enable is 1. Queues that share a port and queues on separate ports count alike. The default map (2 bits per queue, queue 0 in bits 1:0) puts queues 0 and 1 on port 0, queue 2 on port 1 and queue 3 on port 2.
- R8: `actor_en_o` equals the merged enable of the previous cycle, adding one cycle of latency both when the clock stops and when it restarts.
- R9: Each high phase of `actor_clk_o` is either a full copy of the `dom_clk` high phase, when `actor_en_o` was 1 during the preceding low phase, or stays low throughout. `actor_clk_o` is 0 whenever `dom_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dom_clk | input | 1 | Free-running domain clock |
| rst | input | 1 | Asynchronous active-high reset |
| q_full_i | input | NUM_Q | Full flag of each output queue |
| q_afull_i | input | NUM_Q | Almost-full flag of each output queue (one slot left) |
| actor_clk_o | output | 1 | Gated clock for the actor and its queues |
| actor_en_o | output | 1 | Registered merged enable |

## Verification
Two things can happen in the same cycle: one queue releases its backpressure while another queue starts asserting it. The bench provokes this in two ways. In one, queue 0 drops full on the same edge that queue 3 raises almost-full. In the other, queues on separate ports swap their flags together. A reference model, one behavioural state per queue, predicts that the merged enable stays low across the swap, and the bench compares `actor_en_o` and every gated high phase against it each cycle. A long random walk over all flags then mixes simultaneous releases, stalls and fan-out collisions.

// File: rtl/actor_clk_pkg.sv
package actor_clk_pkg;

    typedef enum logic [2:0] {
        CS_START  = 3'd0,
        CS_FREE   = 3'd1,
        CS_HOLD   = 3'd2,
        CS_STOP   = 3'd3,
        CS_RESUME = 3'd4
    } ctl_state_t;

    typedef struct packed {
        ctl_state_t state;
    } ctl_reg_t;

    typedef struct packed {
        logic en;
    } gate_reg_t;

    localparam int unsigned MAX_Q        = 4;
    localparam int unsigned PORT_IDX_W   = 2;

endpackage

// File: rtl/queue_bp_ctrl.sv
module queue_bp_ctrl
    import actor_clk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic full_i,
    input  logic afull_i,
    output logic en_o
);

    ctl_reg_t r_d;
    ctl_reg_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            CS_START: begin
                if (!full_i && !afull_i) r_d.state = CS_FREE;
            end
            CS_FREE: begin
                if (full_i || afull_i) r_d.state = CS_HOLD;
            end
            CS_HOLD: begin
                if (full_i)        r_d.state = CS_STOP;
                else if (!afull_i) r_d.state = CS_RESUME;
            end
            CS_STOP: begin
                if (!full_i) r_d.state = CS_RESUME;
            end
            CS_RESUME: begin
                if (full_i)       r_d.state = CS_STOP;
                else if (afull_i) r_d.state = CS_HOLD;
                else              r_d.state = CS_FREE;
            end
            default: r_d.state = CS_START;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q.state <= CS_START;
        else     r_q <= r_d;
    end

    always_comb begin
        en_o = (r_q.state == CS_START) || (r_q.state == CS_FREE) ||
               (r_q.state == CS_RESUME);
    end

endmodule

// File: rtl/port_en_merge.sv
module port_en_merge
    import actor_clk_pkg::*;
#(
    parameter int unsigned NUM_Q     = 4,
    parameter int unsigned NUM_PORTS = 3,
    parameter logic [MAX_Q*PORT_IDX_W-1:0] PORT_MAP = 8'b10_01_00_00
) (
    input  logic [NUM_Q-1:0] q_en_i,
    output logic             merged_o
);

    logic [NUM_PORTS-1:0] port_en;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            port_en[p] = 1'b1;
            for (int q = 0; q < NUM_Q; q++) begin
                if (PORT_MAP[PORT_IDX_W*q +: PORT_IDX_W] == PORT_IDX_W'(p))
                    port_en[p] = port_en[p] & q_en_i[q];
            end
        end
    end

    always_comb begin
        merged_o = &port_en;
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    always_latch begin
        if (rst)       en_lat = 1'b1;
        else if (!clk) en_lat = en_i;
    end

    assign gclk_o = clk & en_lat;

endmodule

// File: rtl/actor_clk_enabler.sv
module actor_clk_enabler
    import actor_clk_pkg::*;
#(
    parameter int unsigned NUM_Q     = 4,
    parameter int unsigned NUM_PORTS = 3,
    parameter logic [MAX_Q*PORT_IDX_W-1:0] PORT_MAP = 8'b10_01_00_00
) (
    input  logic             dom_clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] q_full_i,
    input  logic [NUM_Q-1:0] q_afull_i,
    output logic             actor_clk_o,
    output logic             actor_en_o
);

    logic [NUM_Q-1:0] q_en;
    logic             merged_en;
    gate_reg_t        g_d;
    gate_reg_t        g_q;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_ctl
        queue_bp_ctrl u_ctl (
            .clk     (dom_clk),
            .rst     (rst),
            .full_i  (q_full_i[i]),
            .afull_i (q_afull_i[i]),
            .en_o    (q_en[i])
        );
    end

    port_en_merge #(
        .NUM_Q     (NUM_Q),
        .NUM_PORTS (NUM_PORTS),
        .PORT_MAP  (PORT_MAP)
    ) u_merge (
        .q_en_i   (q_en),
        .merged_o (merged_en)
    );

    always_comb begin
        g_d    = g_q;
        g_d.en = merged_en;
    end

    always_ff @(posedge dom_clk or posedge rst) begin
        if (rst) g_q.en <= 1'b1;
        else     g_q <= g_d;
    end

    assign actor_en_o = g_q.en;

    clk_gate_cell u_gate (
        .clk    (dom_clk),
        .rst    (rst),
        .en_i   (g_q.en),
        .gclk_o (actor_clk_o)
    );

endmodule

// File: rtl/actor_clk_enabler_chk.sv
module actor_clk_enabler_chk #(
    parameter int unsigned NUM_Q = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NUM_Q-1:0] q_full,
    input logic [NUM_Q-1:0] q_en,
    input logic             merged_en,
    input logic             en_q,
    input logic             gclk
);

    // R8
    en_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> en_q == $past(merged_en));

    // R7
    merge_all_chk: assert property (@(posedge clk) disable iff (rst)
        merged_en |-> (&q_en));

    // R7
    merge_any_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(&q_en) |-> !merged_en);

    // R9
    gated_phase_chk: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> gclk == $past(en_q));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        // R5
        stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!q_en[i] && q_full[i]) |=> !q_en[i]);

        // R4
        release_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(q_en[i]) |-> !$past(q_full[i]));
    end

endmodule

bind actor_clk_enabler actor_clk_enabler_chk #(.NUM_Q(NUM_Q)) u_chk (
    .clk       (dom_clk),
    .rst       (rst),
    .q_full    (q_full_i),
    .q_en      (q_en),
    .merged_en (merged_en),
    .en_q      (actor_en_o),
    .gclk      (actor_clk_o)
);

// File: tb/actor_clk_enabler_test.sv
module actor_clk_enabler_test;

    localparam int NQ = 4;

    logic          dom_clk = 1'b0;
    logic          rst     = 1'b1;
    logic [NQ-1:0] q_full  = '0;
    logic [NQ-1:0] q_afull = '0;
    logic          actor_clk;
    logic          actor_en;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    int st [NQ];
    bit exp_en  = 1'b1;
    bit exp_lat = 1'b1;

    actor_clk_enabler uut (
        .dom_clk     (dom_clk),
        .rst         (rst),
        .q_full_i    (q_full),
        .q_afull_i   (q_afull),
        .actor_clk_o (actor_clk),
        .actor_en_o  (actor_en)
    );

    always #10 dom_clk = ~dom_clk;

    // Model states: 0 start, 1 free, 2 hold-off, 3 stopped, 4 resume (R2..R6)
    function automatic bit st_en(int s);
        return (s == 0) || (s == 1) || (s == 4);
    endfunction

    function automatic int st_next(int s, bit f, bit a);
        case (s)
            0: return (!f && !a) ? 1 : 0;
            1: return (f || a) ? 2 : 1;
            2: return f ? 3 : (!a ? 4 : 2);
            3: return f ? 3 : 4;
            default: return f ? 3 : (a ? 2 : 1);
        endcase
    endfunction

    always @(posedge dom_clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < NQ; i++) st[i] = 0;
            exp_en = 1'b1;
        end else begin
            bit all_en;
            all_en = 1'b1;
            for (int i = 0; i < NQ; i++) all_en = all_en & st_en(st[i]);
            exp_en = all_en;  // R8: one register of latency
            for (int i = 0; i < NQ; i++) st[i] = st_next(st[i], q_full[i], q_afull[i]);
        end
    end

    always @(negedge dom_clk) exp_lat = rst ? 1'b1 : exp_en;

    task automatic check(string req, string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Enable compared each cycle after the negative edge (R2..R8)
    always @(negedge dom_clk) begin
        #2;
        if (!done) check(cur_req, "actor_en_o", actor_en, rst ? 1'b1 : exp_en);
    end

    // Gated clock checked mid high phase and mid low phase (R9, R1)
    always @(posedge dom_clk) begin
        #5;
        if (!done) check(rst ? "R1" : "R9", "actor_clk_o high phase", actor_clk, exp_lat);
        #10;
        if (!done) check("R9", "actor_clk_o low phase", actor_clk, 1'b0);
    end

    task automatic drive(logic [NQ-1:0] f, logic [NQ-1:0] a, string req, int cycles);
        @(negedge dom_clk);
        cur_req = req;
        q_full  = f;
        q_afull = a;
        for (int k = 1; k < cycles; k++) @(negedge dom_clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (10000) @(posedge dom_clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset with queue 0 reporting full
        q_full  = 4'b0001;
        q_afull = 4'b0001;
        repeat (3) @(negedge dom_clk);
        check("R1", "reset enable", actor_en, 1'b1);
        rst = 1'b0;
        // R2: start state ignores flags until both clear
        drive(4'b0001, 4'b0001, "R2", 4);
        check("R2", "enable held in start state", actor_en, 1'b1);
        drive(4'b0000, 4'b0000, "R2", 3);
        // R3: almost-full in free state stops the clock
        drive(4'b0000, 4'b0100, "R3", 3);
        check("R3", "enable after almost-full", actor_en, 1'b0);
        // R4: hold-off to stopped, then release to resume
        drive(4'b0100, 4'b0100, "R4", 3);
        drive(4'b0000, 4'b0100, "R5", 3);
        check("R5", "enable after full drops", actor_en, 1'b1);
        // R6: resume with almost-full goes back to hold-off
        drive(4'b0000, 4'b0100, "R6", 3);
        drive(4'b0000, 4'b0000, "R4", 3);
        drive(4'b0000, 4'b0000, "R6", 3);
        // R7: fan-out pair on port 0, one queue at a time
        drive(4'b0010, 4'b0010, "R7", 3);
        drive(4'b0000, 4'b0000, "R7", 4);
        // R7: release of queue 0 in the same cycle queue 3 raises almost-full
        drive(4'b0001, 4'b0001, "R7", 3);
        drive(4'b0000, 4'b1000, "R7", 3);
        check("R7", "enable across release/stall collision", actor_en, 1'b0);
        drive(4'b1000, 4'b1000, "R7", 2);
        drive(4'b0100, 4'b0100, "R7", 2);
        drive(4'b0000, 4'b0000, "R8", 4);
        check("R8", "enable restored", actor_en, 1'b1);
        // R7/R8: random walk across all queues and ports
        for (int k = 0; k < 3000; k++) begin
            logic [NQ-1:0] f;
            logic [NQ-1:0] a;
            f = NQ'($urandom) & NQ'($urandom);
            a = NQ'($urandom) | f;
            drive(f, a, "R7", 1);
        end
        drive(4'b0000, 4'b0000, "R8", 6);
        // R1: reset mid-run returns enable high
        @(negedge dom_clk);
        rst = 1'b1;
        drive(4'b1111, 4'b1111, "R1", 3);
        check("R1", "enable under second reset", actor_en, 1'b1);
        rst = 1'b0;
        drive(4'b0000, 4'b0000, "R2", 4);
        finish_run();
    end

endmodule